// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execution unit of a small load/store processor. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift count, an operation code and a flag that swaps the second register operand for the extended immediate. One clock later it presents a 32-bit result and an overflow-trap flag. The arithmetic group covers add, subtract and set-on-less-than, each in a trapping or checked form and a wrapping or unsigned form. The logical group covers AND, OR, NOR and logical shifts.

The trap flag is raised only by the two checked arithmetic operations. The exception logic outside the block reads it to abandon the write-back. Immediates feeding the logical operations are zero-extended. Immediates feeding arithmetic and compare operations are sign-extended, including the unsigned-named forms. Register access, decode, exception vectoring, multiply and divide are left to the surrounding pipeline.

Top module: `int_alu_core`

## Requirements
- R1: With op_sel = 0 (checked add), the result is src_a plus the second operand modulo 2^32, and ovf_trap is 1 exactly when the two's-complement sum does not fit in 32 bits.
- R2: With op_sel = 1 (wrapping add), the result is the same modulo-2^32 sum and ovf_trap is always 0.
- R3: With op_sel = 2 (checked subtract), the result is src_a minus the second operand modulo 2^32, and ovf_trap is 1 exactly on two's-complement overflow of that difference.
- R4: With op_sel = 3 (wrapping subtract), the result is the same modulo-2^32 difference and ovf_trap is always 0.
- R5: When imm_sel = 1, the second operand is the immediate. For op_sel 4, 5 and 6 (AND, OR, NOR) the immediate is zero-extended, so 0x8001 becomes 0x00008001. For op_sel 0 to 3, 9 and 10 it is sign-extended from bit 15.
- R6: op_sel = 4 gives the bitwise AND, op_sel = 5 the bitwise OR, and op_sel = 6 the inverse of the OR. A NOR with a zero second operand gives ~src_a.
- R7: op_sel = 7 shifts src_a left by shamt and fills the low bits with zeros, so 0x12345678 shifted by 8 gives 0x34567800. src_b, imm and imm_sel have no effect on it.
- R8: op_sel = 8 shifts src_a right by shamt and fills the high bits with zeros, so 0x12345678 shifted by 8 gives 0x00123456.
- R9: op_sel = 9 gives 1 when src_a is less than the second operand as signed numbers and 0 otherwise. op_sel = 10 does the same comparison as unsigned numbers. For 0xFFFFFFFF against 0x00000001 the signed compare gives 1 and the unsigned compare gives 0.
- R10: ovf_trap is 0 for every op_sel other than 0 and 2. The unused codes 11 to 15 give a result of 0.
- R11: Result and trap are registered. Inputs applied before a rising edge appear on the outputs after that edge.
- R12: While rst is high at a rising edge, result and ovf_trap become 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (0 to 10 defined) |
| imm_sel | input | 1 | Use the extended immediate as the second operand |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift count for the shift operations |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | Registered overflow exception flag |

## Verification
The hardest case to reach is one where the checked and wrapping forms must differ on the very same operands. This happens at the signed boundaries, where a carry out of bit 31 and a signed overflow do not coincide: 0x7FFFFFFF plus 1, and 0x80000000 minus 1. The stimulus sends those operand pairs through both forms, and again through the immediate path with an all-ones immediate, so that sign extension is what produces the overflow. The compare tests use the same 0xFFFFFFFF and 0xFFFF values, which makes the signed and unsigned answers come out opposite.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_S = 4'd0,
        OP_ADD_U = 4'd1,
        OP_SUB_S = 4'd2,
        OP_SUB_U = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_NOR   = 4'd6,
        OP_SHL   = 4'd7,
        OP_SHR   = 4'd8,
        OP_SLT_S = 4'd9,
        OP_SLT_U = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_SLT,
        UNIT_LOGIC,
        UNIT_NONE
    } unit_e;

    // Controls for the shared adder/subtractor
    typedef struct packed {
        logic sub;        // invert second operand, carry in 1
        logic signed_ext; // extend operands with their sign bit
        logic trap_en;    // overflow may raise the trap
    } arith_ctl_t;

    function automatic arith_ctl_t arith_ctl(alu_op_e op);
        arith_ctl_t c;
        c.sub        = (op == OP_SUB_S) || (op == OP_SUB_U) ||
                       (op == OP_SLT_S) || (op == OP_SLT_U);
        c.signed_ext = (op == OP_ADD_S) || (op == OP_SUB_S) || (op == OP_SLT_S);
        c.trap_en    = (op == OP_ADD_S) || (op == OP_SUB_S);
        return c;
    endfunction

    function automatic unit_e unit_of(alu_op_e op);
        unit_e u;
        case (op)
            OP_ADD_S, OP_ADD_U, OP_SUB_S, OP_SUB_U: u = UNIT_ARITH;
            OP_SLT_S, OP_SLT_U:                     u = UNIT_SLT;
            OP_AND, OP_OR, OP_NOR, OP_SHL, OP_SHR:  u = UNIT_LOGIC;
            default:                                u = UNIT_NONE;
        endcase
        return u;
    endfunction

    // Logical immediates are zero-extended, everything else sign-extended
    function automatic logic imm_sign_ext(alu_op_e op);
        return !((op == OP_AND) || (op == OP_OR) || (op == OP_NOR));
    endfunction

endpackage

// File: rtl/int_alu_opnd.sv
module int_alu_opnd #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] b_eff
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic              pad_bit;
    logic [DATA_W-1:0] imm_ext;

    assign pad_bit = sign_ext & imm[IMM_W-1];
    assign imm_ext = {{PAD_W{pad_bit}}, imm};
    assign b_eff   = imm_sel ? imm_ext : reg_b;

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  arith_ctl_t        ctl,
    output logic [DATA_W-1:0] sum,
    output logic              trap,
    output logic              less
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] a_x, b_x, b_op, r_x;

    // One extra bit: sign copy for signed forms, zero for unsigned forms
    assign a_x  = {ctl.signed_ext & opa[DATA_W-1], opa};
    assign b_x  = {ctl.signed_ext & opb[DATA_W-1], opb};
    assign b_op = ctl.sub ? ~b_x : b_x;
    assign r_x  = a_x + b_op + EXT_W'(ctl.sub);

    assign sum  = r_x[DATA_W-1:0];
    // Extended result's top bit is the true sign of a - b in both modes
    assign less = r_x[EXT_W-1];
    // A result that needs the extra bit did not fit in DATA_W signed bits
    assign trap = ctl.trap_en & (r_x[EXT_W-1] ^ r_x[DATA_W-1]);

endmodule

// File: rtl/int_alu_logic_shift.sv
module int_alu_logic_shift
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  res
);
    logic [DATA_W-1:0] lstage [SHAMT_W+1];
    logic [DATA_W-1:0] rstage [SHAMT_W+1];

    assign lstage[0] = opa;
    assign rstage[0] = opa;

    // Log-depth barrel shifter, one stage per bit of the shift count
    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        assign lstage[i+1] = shamt[i] ? (lstage[i] << (2**i)) : lstage[i];
        assign rstage[i+1] = shamt[i] ? (rstage[i] >> (2**i)) : rstage[i];
    end

    always_comb begin
        case (op)
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_NOR:  res = ~(opa | opb);
            OP_SHL:  res = lstage[SHAMT_W];
            OP_SHR:  res = rstage[SHAMT_W];
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    op_sel,
    input  logic               imm_sel,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  result,
    output logic               ovf_trap
);
    alu_op_e           op;
    arith_ctl_t        actl;
    unit_e             unit;
    logic [DATA_W-1:0] b_eff, arith_sum, ls_res, nxt_res, result_q;
    logic              arith_trap, arith_lt, nxt_ovf, ovf_q;

    assign op   = alu_op_e'(op_sel);
    assign actl = arith_ctl(op);
    assign unit = unit_of(op);

    int_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .reg_b    (src_b),
        .imm      (imm),
        .imm_sel  (imm_sel),
        .sign_ext (imm_sign_ext(op)),
        .b_eff    (b_eff)
    );

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa  (src_a),
        .opb  (b_eff),
        .ctl  (actl),
        .sum  (arith_sum),
        .trap (arith_trap),
        .less (arith_lt)
    );

    int_alu_logic_shift #(.DATA_W(DATA_W)) u_lsh (
        .op    (op),
        .opa   (src_a),
        .opb   (b_eff),
        .shamt (shamt),
        .res   (ls_res)
    );

    always_comb begin
        case (unit)
            UNIT_ARITH: nxt_res = arith_sum;
            UNIT_SLT:   nxt_res = {{(DATA_W-1){1'b0}}, arith_lt};
            UNIT_LOGIC: nxt_res = ls_res;
            default:    nxt_res = '0;
        endcase
        nxt_ovf = (unit == UNIT_ARITH) && arith_trap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            result_q <= nxt_res;
            ovf_q    <= nxt_ovf;
        end
    end

    assign result   = result_q;
    assign ovf_trap = ovf_q;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> ($past(op) == OP_ADD_S || $past(op) == OP_SUB_S));

    // R9
    slt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op) == OP_SLT_S || $past(op) == OP_SLT_U))
        |-> (result_q[DATA_W-1:1] == '0));

    // R7
    shl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_SHL && $past(shamt) != '0)
        |-> (result_q[0] == 1'b0));

    // R8
    shr_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_SHR && $past(shamt) != '0)
        |-> (result_q[DATA_W-1] == 1'b0));

    // R6
    nor_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_NOR)
        |-> ((result_q & ($past(src_a) | $past(b_eff))) == '0));

    // R2
    wrap_add_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_ADD_U)
        |-> (result_q == $past(src_a + b_eff) && !ovf_q));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (result_q == '0 && !ovf_q));

endmodule

// File: tb/int_alu_core_test.sv
module int_alu_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t scb[$];

    always #10 clk = ~clk;

    int_alu_core uut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .imm_sel(imm_sel),
        .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
        .result(result), .ovf_trap(ovf_trap)
    );

    task automatic check(string tag, logic [31:0] got_r, logic got_o,
                         logic [31:0] exp_r, logic exp_o);
        n_cmp++;
        if (got_r !== exp_r || got_o !== exp_o) begin
            n_bad++;
            $display("FAIL %s: got result=%h trap=%b, expected result=%h trap=%b",
                     tag, got_r, got_o, exp_r, exp_o);
        end
    endtask

    // Expected behaviour taken from the requirement list
    function automatic void model(input logic [3:0] op, input logic isel,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] im, input logic [4:0] sh,
                                  output logic [31:0] r, output logic o);
        logic [31:0] bv;
        longint sa, sb, wide;
        if (!isel)
            bv = b;
        else if (op == 4 || op == 5 || op == 6)
            bv = {16'h0000, im};
        else
            bv = {{16{im[15]}}, im};
        sa = longint'($signed(a));
        sb = longint'($signed(bv));
        o = 1'b0;
        case (op)
            4'd0, 4'd1: begin
                wide = sa + sb;
                r = wide[31:0];
                if (op == 0) o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                wide = sa - sb;
                r = wide[31:0];
                if (op == 2) o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            4'd4:  r = a & bv;
            4'd5:  r = a | bv;
            4'd6:  r = ~(a | bv);
            4'd7:  r = a << sh;
            4'd8:  r = a >> sh;
            4'd9:  r = (sa < sb) ? 32'd1 : 32'd0;
            4'd10: r = (a < bv) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
    endfunction

    // Driver: applies one operation and queues its expected outcome
    task automatic apply(string tag, logic [3:0] op, logic isel, logic [31:0] a,
                         logic [31:0] b, logic [15:0] im, logic [4:0] sh);
        exp_t e;
        @(negedge clk);
        op_sel = op; imm_sel = isel; src_a = a; src_b = b; imm = im; shamt = sh;
        model(op, isel, a, b, im, sh, e.res, e.ovf);
        e.tag = tag;
        scb.push_back(e);
    endtask

    // Same as apply, but the expected values are given directly
    task automatic apply_fixed(string tag, logic [3:0] op, logic isel, logic [31:0] a,
                               logic [31:0] b, logic [15:0] im, logic [4:0] sh,
                               logic [31:0] er, logic eo);
        exp_t e;
        @(negedge clk);
        op_sel = op; imm_sel = isel; src_a = a; src_b = b; imm = im; shamt = sh;
        e.res = er; e.ovf = eo; e.tag = tag;
        scb.push_back(e);
    endtask

    // Monitor: a queued item was applied before the last edge (R11)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                check(e.tag, result, ovf_trap, e.res, e.ovf);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset dominates over live inputs
        op_sel = 4'd0; src_a = 32'h7FFFFFFF; src_b = 32'h1;
        repeat (3) @(posedge clk);
        #5;
        check("R12 reset", result, ovf_trap, 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1 checked add
        apply_fixed("R1 add overflow", 4'd0, 0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 1);
        apply_fixed("R1 add no overflow", 4'd0, 0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 0);
        apply_fixed("R1 R5 addi negative imm overflow", 4'd0, 1, 32'h80000000, 32'h0, 16'hFFFF, 5'd0, 32'h7FFFFFFF, 1);
        apply("R1 add mixed", 4'd0, 0, 32'h12345678, 32'h11111111, 16'h0, 5'd0);
        // R2 wrapping add
        apply_fixed("R2 add wraps quietly", 4'd1, 0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 0);
        apply_fixed("R2 R5 addiu sign-extended", 4'd1, 1, 32'h5, 32'h0, 16'hFFFF, 5'd0, 32'h4, 0);
        // R3 checked subtract
        apply_fixed("R3 sub overflow", 4'd2, 0, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1);
        apply_fixed("R3 sub plain", 4'd2, 0, 32'd10, 32'd3, 16'h0, 5'd0, 32'd7, 0);
        apply_fixed("R3 sub pos minus neg overflow", 4'd2, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h80000000, 1);
        // R4 wrapping subtract
        apply_fixed("R4 sub wraps quietly", 4'd3, 0, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 0);
        apply_fixed("R4 sub below zero", 4'd3, 0, 32'd3, 32'd10, 16'h0, 5'd0, 32'hFFFFFFF9, 0);
        // R5 zero-extended logical immediates
        apply_fixed("R5 andi zero-extend", 4'd4, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001, 5'd0, 32'h00008001, 0);
        apply_fixed("R5 ori zero-extend", 4'd5, 1, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h00008000, 0);
        apply_fixed("R5 andi one", 4'd4, 1, 32'hFFFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h00000001, 0);
        // R6 logic
        apply("R6 and", 4'd4, 0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0);
        apply("R6 or", 4'd5, 0, 32'hF0F0F0F0, 32'h0F0000FF, 16'h0, 5'd0);
        apply_fixed("R6 nor with zero is not", 4'd6, 0, 32'h12345678, 32'h0, 16'h0, 5'd0, 32'hEDCBA987, 0);
        // R7 / R8 shifts
        apply_fixed("R7 shift left 8", 4'd7, 0, 32'h12345678, 32'hFFFFFFFF, 16'h0, 5'd8, 32'h34567800, 0);
        apply_fixed("R7 shift left ignores imm", 4'd7, 1, 32'h12345678, 32'h0, 16'hFFFF, 5'd8, 32'h34567800, 0);
        apply_fixed("R7 shift left 31", 4'd7, 0, 32'h00000003, 32'h0, 16'h0, 5'd31, 32'h80000000, 0);
        apply_fixed("R8 shift right 8", 4'd8, 0, 32'h12345678, 32'h0, 16'h0, 5'd8, 32'h00123456, 0);
        apply_fixed("R8 shift right 31", 4'd8, 0, 32'h80000000, 32'h0, 16'h0, 5'd31, 32'h00000001, 0);
        apply_fixed("R8 shift right 0", 4'd8, 0, 32'hDEADBEEF, 32'h0, 16'h0, 5'd0, 32'hDEADBEEF, 0);
        // R9 compares
        apply_fixed("R9 slt signed", 4'd9, 0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h1, 0);
        apply_fixed("R9 slt unsigned", 4'd10, 0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 0);
        apply_fixed("R9 R5 slti imm -1", 4'd9, 1, 32'h0, 32'h0, 16'hFFFF, 5'd0, 32'h0, 0);
        apply_fixed("R9 R5 sltiu imm all ones", 4'd10, 1, 32'h0, 32'h0, 16'hFFFF, 5'd0, 32'h1, 0);
        apply_fixed("R9 slt signed extremes", 4'd9, 0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, 32'h1, 0);
        apply_fixed("R9 slt equal", 4'd10, 0, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 0);
        // R10 no trap outside checked arithmetic, unused codes give 0
        apply_fixed("R10 nor no trap", 4'd6, 0, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'h0, 0);
        apply_fixed("R10 unused code 11", 4'd11, 0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd4, 32'h0, 0);
        apply_fixed("R10 unused code 15", 4'd15, 1, 32'hFFFFFFFF, 32'h1, 16'hFFFF, 5'd1, 32'h0, 0);
        // R1/R3 sweep over sign boundaries through both forms
        for (int k = 0; k < 24; k++) begin
            logic [31:0] a, b;
            a = 32'h7FFFFFF0 + 32'(k) * 32'h08000001;
            b = 32'h00000010 ^ (32'(k) << 27);
            apply("R1 sweep", 4'd0, 0, a, b, 16'h0, 5'd0);
            apply("R2 sweep", 4'd1, 0, a, b, 16'h0, 5'd0);
            apply("R3 sweep", 4'd2, 0, a, b, 16'h0, 5'd0);
            apply("R4 sweep", 4'd3, 0, a, b, 16'h0, 5'd0);
            apply("R9 sweep", 4'd9, 1, a, b, 16'(b ^ 32'h8000), 5'd0);
        end
        // R11: one-cycle latency with back-to-back changes
        apply_fixed("R11 back-to-back a", 4'd5, 0, 32'h1, 32'h2, 16'h0, 5'd0, 32'h3, 0);
        apply_fixed("R11 back-to-back b", 4'd4, 0, 32'h1, 32'h2, 16'h0, 5'd0, 32'h0, 0);
        // R12: reset mid-run clears a trapping result
        apply_fixed("R1 before reset", 4'd0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 5'd0, 32'hFFFFFFFE, 1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R12 reset mid-run", result, ovf_trap, 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule